// File: doc/BRIEF.md
# Parallel Video Capture Window

This block is the receiving edge of a parallel camera port. It samples twelve pixel data pins and a horizontal and a vertical sync pin on the pixel clock. A per-pin enable mask gates each pin, and either sync pin can be inverted. It then finds the rising edge of each sync signal after inversion. After each vertical sync edge it waits a programmed number of clocks before it accepts any line. After each accepted horizontal sync edge it waits a programmed number of clocks and then emits a run of pixels of the programmed width. The stream carries a valid qualifier, a start-of-frame flag and an end-of-line flag.

Software writes a small register file through a one-cycle write strobe. Register 0 is control. Writing 1 to bit 0 requests capture and writing 1 to bit 2 withdraws the request. A zero in either bit does nothing. The request is only sampled at a vertical sync edge, so output always holds whole frames. Every vertical sync edge also raises a one-cycle frame event, meant for an external completion counter.

Top module: `pix_window_capture`

## Requirements
- R1: While reset is asserted and until the first sync edge after it, pixValid, pixSof, pixEol, frameEvent and capActive are low and pixData is zero.
- R2: Register 1 is the pin enable mask: bits 11:0 enable data pins 11:0, bit 13 enables HSYNC and bit 14 enables VSYNC (0x6FFF enables all). A disabled pin reads as 0, so a disabled sync pin produces no edges and a disabled data bit is zero in pixData. The reset value is 0.
- R3: Register 2 bit 1 inverts HSYNC and bit 2 inverts VSYNC before edge detection, so an active-low sync pulse is detected on its falling pin edge.
- R4: Writing register 0 with bit 0 set requests capture. capActive rises, and capture starts, one clock edge after the edge that first samples the (effective) VSYNC high.
- R5: Writing register 0 with bits 0 and 2 both zero leaves the capture request unchanged. Writing both bits as 1 withdraws the request (stop wins).
- R6: Writing register 0 with bit 2 set withdraws the request. The frame in progress completes, and capActive falls at the next VSYNC edge.
- R7: Each effective VSYNC rising edge gives a one-cycle frameEvent, one clock edge after the edge that samples it, whether capturing or not.
- R8: Register 4 holds the height in bits 31:16 and the vertical delay V in bits 15:0. An HSYNC edge sampled at edge kh after a VSYNC edge sampled at kv is counted as a line only if kh >= kv+1+V and kh != kv. Only the first height such lines of a capturing frame emit pixels.
- R9: Register 3 holds the width in bits 31:16 and the horizontal delay H in bits 15:0. For a counted line whose HSYNC is sampled at edge k, pixel j (j from 0 to width-1) is valid after edge k+2+H+j and carries the data pins sampled at edge k+1+H+j. A later HSYNC or VSYNC edge cuts the line short.
- R10: pixSof marks the first valid pixel of each captured frame. pixEol marks the pixel with j = width-1; a line cut short has no pixEol.
- R11: A width or height of zero gives no valid pixels in the frame, while frameEvent still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Register write data |
| pinData | input | 12 | Pixel data pins |
| pinHsync | input | 1 | Horizontal sync pin |
| pinVsync | input | 1 | Vertical sync pin |
| pixData | output | 12 | Output pixel, zero when not valid |
| pixValid | output | 1 | Pixel qualifier |
| pixSof | output | 1 | First pixel of a frame |
| pixEol | output | 1 | Last pixel of a full line |
| frameEvent | output | 1 | One-cycle pulse per VSYNC edge |
| capActive | output | 1 | Current frame is being captured |

## Verification
A wrong line counter or a wrong vertical delay count shows up as a missing or extra run of valid pixels at the next HSYNC edge. A wrong horizontal position shows within one line as a shifted pixValid window or a misplaced pixEol. A corrupted capture request stays hidden until the next VSYNC edge. There, capActive and the presence of pixels in the following frame show it. For that reason, every stop and zero-write case is followed by at least one full frame. A wrong start-of-frame tracker shows on the first pixel of the next frame.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  // Register indices
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_PINEN = 1;
  localparam int unsigned ADDR_INV   = 2;
  localparam int unsigned ADDR_HACT  = 3;
  localparam int unsigned ADDR_VACT  = 4;
  // Bit positions inside registers
  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 2;
  localparam int unsigned INV_H_BIT      = 1;
  localparam int unsigned INV_V_BIT      = 2;
  localparam int unsigned EN_H_BIT       = 13;
  localparam int unsigned EN_V_BIT       = 14;

  // Strobes from control to the pixel datapath
  typedef struct packed {
    logic lineRestart;  // any horizontal sync edge
    logic lineGo;       // horizontal edge accepted as an active line
    logic frameEdge;    // any vertical sync edge
    logic frameOpen;    // vertical edge that opens a captured frame
  } pvcStrobe_t;
endpackage

// File: rtl/pvc_sync.sv
module pvc_sync #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pinData,
  input  logic              pinHsync,
  input  logic              pinVsync,
  input  logic [DATA_W-1:0] enData,
  input  logic              enH,
  input  logic              enV,
  input  logic              invH,
  input  logic              invV,
  output logic [DATA_W-1:0] smpData,
  output logic              hRise,
  output logic              vRise
);
  logic smpH, smpV, prevH, prevV;
  logic effH, effV;

  assign effH  = smpH ^ invH;
  assign effV  = smpV ^ invV;
  assign hRise = effH & ~prevH;
  assign vRise = effV & ~prevV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpData <= '0;
      smpH    <= 1'b0;
      smpV    <= 1'b0;
      prevH   <= 1'b0;
      prevV   <= 1'b0;
    end else begin
      smpData <= pinData & enData;
      smpH    <= pinHsync & enH;
      smpV    <= pinVsync & enV;
      prevH   <= effH;
      prevV   <= effV;
    end
  end
endmodule

// File: rtl/pvc_ctrl.sv
module pvc_ctrl
  import pvc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [2*CNT_W-1:0]   regWrData,
  input  logic                 hRise,
  input  logic                 vRise,
  output logic [DATA_W-1:0]    enData,
  output logic                 enH,
  output logic                 enV,
  output logic                 invH,
  output logic                 invV,
  output logic [CNT_W-1:0]     hPorch,
  output logic [CNT_W-1:0]     hWidth,
  output pvcStrobe_t           strobe,
  output logic                 capActive
);
  localparam int POS_W = CNT_W + 2;

  logic [CNT_W-1:0] vPorch, vHeight, lineCnt;
  logic [POS_W-1:0] vPos;
  logic             runReq, frameActive, vOpen, lineGo;
  logic             wrCtrl, wrPinEn, wrInv, wrHact, wrVact;

  assign wrCtrl  = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign wrPinEn = regWrEn && (regAddr == ADDR_W'(ADDR_PINEN));
  assign wrInv   = regWrEn && (regAddr == ADDR_W'(ADDR_INV));
  assign wrHact  = regWrEn && (regAddr == ADDR_W'(ADDR_HACT));
  assign wrVact  = regWrEn && (regAddr == ADDR_W'(ADDR_VACT));

  assign vOpen  = vPos >= {2'b00, vPorch};
  assign lineGo = hRise && !vRise && frameActive && vOpen && (lineCnt < vHeight);

  always_comb begin
    strobe.lineRestart = hRise;
    strobe.lineGo      = lineGo;
    strobe.frameEdge   = vRise;
    strobe.frameOpen   = vRise && runReq;
  end
  assign capActive = frameActive;

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enData  <= '0;
      enH     <= 1'b0;
      enV     <= 1'b0;
      invH    <= 1'b0;
      invV    <= 1'b0;
      hPorch  <= '0;
      hWidth  <= '0;
      vPorch  <= '0;
      vHeight <= '0;
      runReq  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        if (regWrData[CTRL_STOP_BIT])       runReq <= 1'b0;
        else if (regWrData[CTRL_START_BIT]) runReq <= 1'b1;
      end
      if (wrPinEn) begin
        enData <= regWrData[DATA_W-1:0];
        enH    <= regWrData[EN_H_BIT];
        enV    <= regWrData[EN_V_BIT];
      end
      if (wrInv) begin
        invH <= regWrData[INV_H_BIT];
        invV <= regWrData[INV_V_BIT];
      end
      if (wrHact) begin
        hWidth <= regWrData[2*CNT_W-1:CNT_W];
        hPorch <= regWrData[CNT_W-1:0];
      end
      if (wrVact) begin
        vHeight <= regWrData[2*CNT_W-1:CNT_W];
        vPorch  <= regWrData[CNT_W-1:0];
      end
    end
  end

  // Frame gating and vertical window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      vPos        <= '0;
      lineCnt     <= '0;
    end else begin
      if (vRise) begin
        frameActive <= runReq;
        vPos        <= '0;
        lineCnt     <= '0;
      end else begin
        if (vPos != '1) vPos <= vPos + 1'b1;
        if (lineGo)     lineCnt <= lineCnt + 1'b1;
      end
    end
  end

  // Capture state moves only at a vertical edge
  p_hold_until_vsync_r4: assert property (@(posedge clk) disable iff (!rstN)
    !vRise |=> $stable(frameActive));
  // A control write with both command bits clear changes nothing
  p_zero_write_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !regWrData[CTRL_START_BIT] && !regWrData[CTRL_STOP_BIT]) |=> $stable(runReq));
  // A stop command always withdraws the request
  p_stop_withdraws_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && regWrData[CTRL_STOP_BIT]) |=> !runReq);
endmodule

// File: rtl/pvc_pixel.sv
module pvc_pixel
  import pvc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] smpData,
  input  pvcStrobe_t        strobe,
  input  logic [CNT_W-1:0]  hPorch,
  input  logic [CNT_W-1:0]  hWidth,
  output logic [DATA_W-1:0] pixData,
  output logic              pixValid,
  output logic              pixSof,
  output logic              pixEol,
  output logic              frameEvent
);
  localparam int POS_W = CNT_W + 2;

  logic [POS_W-1:0] hPos, rel;
  logic             lineLive, sofPend, inWin, lastPix;

  assign rel     = hPos - {2'b00, hPorch};
  assign inWin   = lineLive && (hPos >= {2'b00, hPorch}) && (rel < {2'b00, hWidth});
  assign lastPix = inWin && ((rel + 1'b1) == {2'b00, hWidth});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPos       <= '0;
      lineLive   <= 1'b0;
      sofPend    <= 1'b0;
      pixData    <= '0;
      pixValid   <= 1'b0;
      pixSof     <= 1'b0;
      pixEol     <= 1'b0;
      frameEvent <= 1'b0;
    end else begin
      if (strobe.lineRestart) hPos <= '0;
      else if (hPos != '1)    hPos <= hPos + 1'b1;

      if (strobe.frameEdge)        lineLive <= 1'b0;
      else if (strobe.lineRestart) lineLive <= strobe.lineGo;

      if (strobe.frameEdge) sofPend <= strobe.frameOpen;
      else if (inWin)       sofPend <= 1'b0;

      pixValid   <= inWin;
      pixData    <= inWin ? smpData : '0;
      pixSof     <= inWin && sofPend;
      pixEol     <= lastPix;
      frameEvent <= strobe.frameEdge;
    end
  end

  p_eol_on_pixel_r10: assert property (@(posedge clk) disable iff (!rstN)
    pixEol |-> pixValid);
  p_sof_on_pixel_r10: assert property (@(posedge clk) disable iff (!rstN)
    pixSof |-> pixValid);
  // An edge needs a low cycle before it, so events never touch
  p_event_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameEvent |=> !frameEvent);
endmodule

// File: rtl/pix_window_capture.sv
module pix_window_capture
  import pvc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [2*CNT_W-1:0]  regWrData,
  input  logic [DATA_W-1:0]   pinData,
  input  logic                pinHsync,
  input  logic                pinVsync,
  output logic [DATA_W-1:0]   pixData,
  output logic                pixValid,
  output logic                pixSof,
  output logic                pixEol,
  output logic                frameEvent,
  output logic                capActive
);
  logic [DATA_W-1:0] enData, smpData;
  logic              enH, enV, invH, invV, hRise, vRise;
  logic [CNT_W-1:0]  hPorch, hWidth;
  pvcStrobe_t        strobe;

  pvc_sync #(.DATA_W(DATA_W)) uSync (
    .clk(clk), .rstN(rstN), .pinData(pinData), .pinHsync(pinHsync), .pinVsync(pinVsync),
    .enData(enData), .enH(enH), .enV(enV), .invH(invH), .invV(invV),
    .smpData(smpData), .hRise(hRise), .vRise(vRise)
  );

  pvc_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .hRise(hRise), .vRise(vRise), .enData(enData), .enH(enH), .enV(enV),
    .invH(invH), .invV(invV), .hPorch(hPorch), .hWidth(hWidth),
    .strobe(strobe), .capActive(capActive)
  );

  pvc_pixel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uPixel (
    .clk(clk), .rstN(rstN), .smpData(smpData), .strobe(strobe),
    .hPorch(hPorch), .hWidth(hWidth), .pixData(pixData), .pixValid(pixValid),
    .pixSof(pixSof), .pixEol(pixEol), .frameEvent(frameEvent)
  );
endmodule

// File: tb/pix_window_capture_test.sv
module pix_window_capture_test;
  localparam int SAT = 262143;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [11:0] pinData = '0;
  logic        pinHsync = 1'b0;
  logic        pinVsync = 1'b0;
  logic [11:0] pixData;
  logic        pixValid, pixSof, pixEol, frameEvent, capActive;

  pix_window_capture uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .pinData(pinData), .pinHsync(pinHsync), .pinVsync(pinVsync),
    .pixData(pixData), .pixValid(pixValid), .pixSof(pixSof), .pixEol(pixEol),
    .frameEvent(frameEvent), .capActive(capActive)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int vectors = 0;
  int misses = 0;
  bit live = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mEn, mInv, mHact, mVact;
  int mSd, mSh, mSv, mPh, mPv, mRun, mAct, mVpos, mLcnt, mHpos, mLive, mSof;
  int eValid, eData, eSof, eEol, eEvt;
  int hEff, vEff, hR, vR, lg, win, rel, hp, wd, vp, ht;

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mInv = 0; mHact = 0; mVact = 0;
      mSd = 0; mSh = 0; mSv = 0; mPh = 0; mPv = 0; mRun = 0; mAct = 0;
      mVpos = 0; mLcnt = 0; mHpos = 0; mLive = 0; mSof = 0;
      eValid = 0; eData = 0; eSof = 0; eEol = 0; eEvt = 0;
    end else begin
      hp = int'(mHact[15:0]); wd = int'(mHact[31:16]);
      vp = int'(mVact[15:0]); ht = int'(mVact[31:16]);
      hEff = mSh ^ int'(mInv[1]);
      vEff = mSv ^ int'(mInv[2]);
      hR = (hEff == 1 && mPh == 0) ? 1 : 0;
      vR = (vEff == 1 && mPv == 0) ? 1 : 0;
      lg = (hR == 1 && vR == 0 && mAct == 1 && mVpos >= vp && mLcnt < ht) ? 1 : 0;
      rel = mHpos - hp;
      win = (mLive == 1 && mHpos >= hp && rel < wd) ? 1 : 0;
      eValid = win;
      eData = win ? mSd : 0;
      eSof = (win == 1 && mSof == 1) ? 1 : 0;
      eEol = (win == 1 && rel == wd - 1) ? 1 : 0;
      eEvt = vR;
      if (vR == 1) mSof = mRun; else if (win == 1) mSof = 0;
      if (vR == 1) begin mAct = mRun; mVpos = 0; mLcnt = 0; end
      else begin
        if (mVpos < SAT) mVpos++;
        if (lg == 1) mLcnt++;
      end
      if (hR == 1) mHpos = 0; else if (mHpos < SAT) mHpos++;
      if (vR == 1) mLive = 0; else if (hR == 1) mLive = lg;
      mSd = int'(pinData & mEn[11:0]);
      mSh = int'(pinHsync & mEn[13]);
      mSv = int'(pinVsync & mEn[14]);
      mPh = hEff; mPv = vEff;
      if (regWrEn) begin
        case (regAddr)
          3'd0: if (regWrData[2]) mRun = 0; else if (regWrData[0]) mRun = 1;
          3'd1: mEn = regWrData;
          3'd2: mInv = regWrData;
          3'd3: mHact = regWrData;
          3'd4: mVact = regWrData;
          default: ;
        endcase
      end
    end
  end

  // ---------------- per-clock comparison and counters ----------------
  int cPix, cSof, cEol, cEvt;
  logic [11:0] dataOr;

  always @(negedge clk) begin
    if (live && rstN) begin
      chk("R4 capActive", int'(capActive), mAct);
      chk("R7 frameEvent", int'(frameEvent), eEvt);
      chk("R9 pixValid", int'(pixValid), eValid);
      chk("R9 pixData", int'(pixData), eData);
      chk("R10 pixSof", int'(pixSof), eSof);
      chk("R10 pixEol", int'(pixEol), eEol);
      if (pixValid) begin cPix++; dataOr = dataOr | pixData; end
      if (pixSof) cSof++;
      if (pixEol) cEol++;
      if (frameEvent) cEvt++;
    end
  end

  task automatic clearCounts();
    cPix = 0; cSof = 0; cEol = 0; cEvt = 0; dataOr = '0;
  endtask

  task automatic regWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'(addr); regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pinData = pinData + 12'd1;
    end
  endtask

  // One frame: VSYNC pulse, front gap, lines of 16 clocks (HSYNC 2 + 14), tail
  task automatic frame(input int nLines, input bit inv);
    pinVsync = ~inv; pinHsync = inv; idle(2);
    pinVsync = inv; idle(10);
    for (int l = 0; l < nLines; l++) begin
      pinHsync = ~inv; idle(2);
      pinHsync = inv;  idle(14);
    end
    idle(10);
  endtask

  initial begin
    clearCounts();
    repeat (2) @(negedge clk);
    chk("R1 reset pixValid", int'(pixValid), 0);
    chk("R1 reset frameEvent", int'(frameEvent), 0);
    chk("R1 reset capActive", int'(capActive), 0);
    chk("R1 reset pixData", int'(pixData), 0);
    rstN = 1'b1;
    live = 1;
    idle(3);
    chk("R1 after reset capActive", int'(capActive), 0);

    // R2: pins disabled by default
    regWrite(3, {16'd8, 16'd3});
    regWrite(4, {16'd4, 16'd5});
    regWrite(0, 32'h1);
    clearCounts();
    frame(6, 0); frame(6, 0);
    chk("R2 no pixels with pins disabled", cPix, 0);
    chk("R2 no events with pins disabled", cEvt, 0);

    // R4/R7/R8/R9/R10: normal capture
    regWrite(1, 32'h6FFF);
    clearCounts();
    frame(6, 0); frame(6, 0);
    chk("R9 pixels in two frames", cPix, 64);
    chk("R10 sof count", cSof, 2);
    chk("R10 eol count", cEol, 8);
    chk("R7 event count", cEvt, 2);
    chk("R4 capActive after start", int'(capActive), 1);

    // R5: zero write ignored
    regWrite(0, 32'h0);
    clearCounts();
    frame(6, 0);
    chk("R5 zero write keeps capture", cPix, 32);

    // R6: stop mid-frame completes frame
    clearCounts();
    fork
      frame(6, 0);
      begin idle(40); regWrite(0, 32'h4); end
    join
    chk("R6 current frame completes", cPix, 32);
    clearCounts();
    frame(6, 0);
    chk("R6 next frame empty", cPix, 0);
    chk("R6 capActive low", int'(capActive), 0);

    // R8: vertical delay drops the early lines
    regWrite(4, {16'd10, 16'd30});
    regWrite(0, 32'h1);
    clearCounts();
    frame(6, 0);
    chk("R8 vertical delay lines", cPix, 32);
    regWrite(4, {16'd4, 16'd5});

    // R3: inverted sync polarity
    pinHsync = 1'b1; pinVsync = 1'b1; idle(4);
    regWrite(2, 32'h6);
    idle(4);
    clearCounts();
    frame(6, 1); frame(6, 1);
    chk("R3 inverted pixels", cPix, 64);
    chk("R3 inverted events", cEvt, 2);
    pinHsync = 1'b0; pinVsync = 1'b0; idle(4);
    regWrite(2, 32'h0);
    idle(4);

    // R11: zero width and zero height
    regWrite(3, {16'd0, 16'd3});
    clearCounts();
    frame(6, 0);
    chk("R11 zero width pixels", cPix, 0);
    chk("R11 zero width eol", cEol, 0);
    chk("R11 zero width event", cEvt, 1);
    regWrite(3, {16'd8, 16'd3});
    regWrite(4, {16'd0, 16'd5});
    clearCounts();
    frame(6, 0);
    chk("R11 zero height pixels", cPix, 0);
    regWrite(4, {16'd4, 16'd5});

    // R2: partial data mask
    regWrite(1, 32'h600F);
    clearCounts();
    frame(6, 0);
    chk("R2 masked frame pixels", cPix, 32);
    chk("R2 masked data bits zero", int'(dataOr & 12'hFF0), 0);
    chk("R2 unmasked data bits seen", int'(dataOr != 12'h000), 1);
    regWrite(1, 32'h6FFF);

    // R9/R10: width longer than the line is cut by the next HSYNC
    regWrite(3, {16'd20, 16'd3});
    clearCounts();
    frame(6, 0);
    chk("R9 truncated pixels", cPix, 52);
    chk("R10 truncated lines no eol", cEol, 0);
    regWrite(3, {16'd8, 16'd3});

    // R5: start and stop together, stop wins
    regWrite(0, 32'h4);
    frame(6, 0);
    regWrite(0, 32'h5);
    clearCounts();
    frame(6, 0);
    chk("R5 both bits stop wins", cPix, 0);
    chk("R5 capActive low", int'(capActive), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule